// File: doc/BRIEF.md
# CAN Error Warning Status Tracker

This block watches the transmit and receive error counters of a CAN controller and keeps two status flags. The error flag marks that at least one counter has passed a programmable warning limit. The bus-off flag marks that the transmit counter has reached the bus-off level. Whenever either flag changes, the block raises a one-cycle warning event for the interrupt unit. The interrupt handler reads the two flags to find the cause: both clear, error only, or both set.

The warning limit is an internal register, 96 after reset, written through a strobe and data port. Counter arithmetic and bus-recovery sequence detection happen elsewhere. This block receives the counter values and a single-cycle strobe that marks the end of recovery.

Top module: `errWarnTracker`

## Requirements
- R1: After reset, errFlag, busOffFlag and warnEvent are all 0, and the warning limit is 96.
- R2: While not bus-off, if txErrCnt or rxErrCnt is strictly greater than the limit at a clock edge, errFlag is 1 after that edge.
- R3: While not bus-off, errFlag clears at an edge where both counters are strictly below the limit. If either counter equals the limit and neither exceeds it, errFlag keeps its value.
- R4: If txErrCnt is 256 or more at an edge while not bus-off, busOffFlag and errFlag are both 1 after that edge.
- R5: While busOffFlag is 1, errFlag stays 1 whatever the counter values are.
- R6: recoverDone high at an edge while busOffFlag is 1 clears both flags after that edge. recoverDone has no effect while busOffFlag is 0.
- R7: warnEvent is 1 for exactly the cycle after the edge at which either flag changed. A change of both flags at the same edge gives a single pulse.
- R8: limitWe high at an edge loads limitIn into the limit. The comparisons at the next edge use the new value.
- R9: While warnEvent is 1, the flag pair {busOffFlag, errFlag} is never 2'b10. 2'b00 means the counters are back below the limit or recovery has finished. 2'b01 means the limit was crossed. 2'b11 means bus-off was entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txErrCnt | input | 9 | Transmit error counter value |
| rxErrCnt | input | 9 | Receive error counter value |
| limitWe | input | 1 | Warning limit write strobe |
| limitIn | input | 8 | New warning limit value |
| recoverDone | input | 1 | Single-cycle bus recovery complete strobe |
| errFlag | output | 1 | Error status flag |
| busOffFlag | output | 1 | Bus-off flag |
| warnEvent | output | 1 | One-cycle warning event pulse |

## Verification
The assertions assume that recoverDone only arrives while the block is bus-off and that reset is held for at least two cycles, so the two-deep history of the flags is defined. They also assume that the counters and limit are sampled only at clock edges. The stimulus holds reset for several cycles and drives every input half a cycle away from the edge. It sends recoverDone mostly when a bus-off has been entered, with a few directed strobes while not bus-off to show that it is ignored. A reference model in the bench follows the counter sweeps across several limits, including 0 and 255.

// File: rtl/ewTrackPkg.sv
package ewTrackPkg;
  typedef struct packed {
    logic overAny;
    logic underAll;
    logic boHit;
  } ewCmp_t;

  typedef struct packed {
    logic setErr;
    logic clrErr;
    logic enterBo;
    logic leaveBo;
  } ewStrobe_t;
endpackage

// File: rtl/ewControl.sv
module ewControl
  import ewTrackPkg::*;
(
  input  ewCmp_t    cmp,
  input  logic      recoverDone,
  input  logic      busOffFlag,
  output ewStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    if (busOffFlag) begin
      strobe.leaveBo = recoverDone;
    end else if (cmp.boHit) begin
      strobe.enterBo = 1'b1;
    end else if (cmp.overAny) begin
      strobe.setErr = 1'b1;
    end else if (cmp.underAll) begin
      strobe.clrErr = 1'b1;
    end
  end
endmodule

// File: rtl/ewDatapath.sv
module ewDatapath
  import ewTrackPkg::*;
#(
  parameter int CNT_W     = 9,
  parameter int LIM_W     = 8,
  parameter int LIMIT_RST = 96
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] txErrCnt,
  input  logic [CNT_W-1:0] rxErrCnt,
  input  logic             limitWe,
  input  logic [LIM_W-1:0] limitIn,
  input  logic             recoverDone,
  input  ewStrobe_t        strobe,
  output ewCmp_t           cmp,
  output logic             errFlag,
  output logic             busOffFlag,
  output logic             warnEvent
);
  localparam int BUS_OFF_LEVEL = 1 << (CNT_W - 1);

  logic [LIM_W-1:0] limitQ;
  logic [CNT_W-1:0] limitExt;
  logic             errQ, boQ, errD, boD, evQ;

  assign limitExt = CNT_W'(limitQ);

  always_comb begin
    cmp.overAny  = (txErrCnt > limitExt) || (rxErrCnt > limitExt);
    cmp.underAll = (txErrCnt < limitExt) && (rxErrCnt < limitExt);
    cmp.boHit    = (txErrCnt >= CNT_W'(BUS_OFF_LEVEL));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      limitQ <= LIM_W'(LIMIT_RST);
      errQ   <= 1'b0;
      boQ    <= 1'b0;
      errD   <= 1'b0;
      boD    <= 1'b0;
      evQ    <= 1'b0;
    end else begin
      if (limitWe) limitQ <= limitIn;
      errD <= errQ;
      boD  <= boQ;
      evQ  <= (errQ != errD) || (boQ != boD);
      if (strobe.leaveBo) begin
        boQ  <= 1'b0;
        errQ <= 1'b0;
      end else if (strobe.enterBo) begin
        boQ  <= 1'b1;
        errQ <= 1'b1;
      end else if (strobe.setErr) begin
        errQ <= 1'b1;
      end else if (strobe.clrErr) begin
        errQ <= 1'b0;
      end
    end
  end

  assign errFlag    = errQ;
  assign busOffFlag = boQ;
  assign warnEvent  = evQ;

  // R2
  errRiseCause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errQ) |-> $past(cmp.overAny || cmp.boHit));
  // R3
  errFallCause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errQ) |-> $past(cmp.underAll || (boQ && recoverDone)));
  // R4
  boEntry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(boQ) |-> $past(cmp.boHit) && errQ);
  // R5
  boHoldsErr_chk: assert property (@(posedge clk) disable iff (!rstN)
    boQ |-> errQ);
  // R6
  boExit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(boQ) |-> $past(recoverDone) && !errQ);
  // R7
  eventTiming_chk: assert property (@(posedge clk) disable iff (!rstN)
    evQ == (($past(errQ) != $past(errQ, 2)) || ($past(boQ) != $past(boQ, 2))));
  // R8
  limitLoad_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(limitWe) |-> limitQ == $past(limitIn));
  // R9
  causeCode_chk: assert property (@(posedge clk) disable iff (!rstN)
    evQ |-> !(boQ && !errQ));
  // R6
  oneStrobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));
endmodule

// File: rtl/errWarnTracker.sv
module errWarnTracker
  import ewTrackPkg::*;
#(
  parameter int CNT_W     = 9,
  parameter int LIM_W     = 8,
  parameter int LIMIT_RST = 96
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] txErrCnt,
  input  logic [CNT_W-1:0] rxErrCnt,
  input  logic             limitWe,
  input  logic [LIM_W-1:0] limitIn,
  input  logic             recoverDone,
  output logic             errFlag,
  output logic             busOffFlag,
  output logic             warnEvent
);
  ewCmp_t    cmp;
  ewStrobe_t strobe;

  ewControl u_ctrl (
    .cmp(cmp), .recoverDone(recoverDone), .busOffFlag(busOffFlag), .strobe(strobe)
  );

  ewDatapath #(.CNT_W(CNT_W), .LIM_W(LIM_W), .LIMIT_RST(LIMIT_RST)) u_dp (
    .clk(clk), .rstN(rstN), .txErrCnt(txErrCnt), .rxErrCnt(rxErrCnt),
    .limitWe(limitWe), .limitIn(limitIn), .recoverDone(recoverDone),
    .strobe(strobe), .cmp(cmp), .errFlag(errFlag), .busOffFlag(busOffFlag),
    .warnEvent(warnEvent)
  );
endmodule

// File: tb/errWarnTracker_bench.sv
module errWarnTracker_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [8:0] txErrCnt = '0, rxErrCnt = '0;
  logic       limitWe = 1'b0, recoverDone = 1'b0;
  logic [7:0] limitIn = '0;
  logic       errFlag, busOffFlag, warnEvent;

  int  nRun = 0, nFail = 0;
  int  mLim = 96;
  bit  mErr, mBo, mErrD, mBoD, mEv;

  always #5 clk = ~clk;

  errWarnTracker u_errWarnTracker (
    .clk(clk), .rstN(rstN), .txErrCnt(txErrCnt), .rxErrCnt(rxErrCnt),
    .limitWe(limitWe), .limitIn(limitIn), .recoverDone(recoverDone),
    .errFlag(errFlag), .busOffFlag(busOffFlag), .warnEvent(warnEvent)
  );

  task automatic check(input string tag);
    nRun++;
    if ({errFlag, busOffFlag, warnEvent} !== {mErr, mBo, mEv}) begin
      nFail++;
      $display("FAIL %s: err/bo/ev actual %b%b%b expected %b%b%b",
               tag, errFlag, busOffFlag, warnEvent, mErr, mBo, mEv);
    end
  endtask

  task automatic step(input int t, input int r, input bit rc, input bit we,
                      input int lim, input string tag);
    @(negedge clk);
    txErrCnt = 9'(t); rxErrCnt = 9'(r); recoverDone = rc;
    limitWe = we; limitIn = 8'(lim);
    @(posedge clk);
    mEv = (mErr != mErrD) || (mBo != mBoD);
    mErrD = mErr; mBoD = mBo;
    if (mBo) begin
      if (rc) begin mBo = 0; mErr = 0; end
    end else if (t >= 256) begin
      mBo = 1; mErr = 1;
    end else if (t > mLim || r > mLim) begin
      mErr = 1;
    end else if (t < mLim && r < mLim) begin
      mErr = 0;
    end
    if (we) mLim = lim;
    #2;
    check(tag);
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int lims[4] = '{96, 0, 255, 40};
    repeat (4) @(posedge clk);
    #2; check("R1");
    @(negedge clk); rstN = 1'b1;
    // R1: reset limit of 96 is in force
    step(96, 96, 0, 0, 0, "R1");
    step(97, 0, 0, 0, 0, "R2");
    step(97, 0, 0, 0, 0, "R7");
    step(96, 10, 0, 0, 0, "R3");
    step(95, 96, 0, 0, 0, "R3");
    step(0, 95, 0, 0, 0, "R3");
    step(0, 95, 0, 0, 0, "R7");
    // R6: recovery ignored when not bus-off
    step(0, 0, 1, 0, 0, "R6");
    step(0, 0, 1, 0, 0, "R6");
    // R4/R7: both flags rise at once, single pulse
    step(300, 0, 0, 0, 0, "R4");
    step(300, 0, 0, 0, 0, "R7");
    step(300, 0, 0, 0, 0, "R9");
    // R5: counters ignored during bus-off
    step(0, 0, 0, 0, 0, "R5");
    step(0, 200, 0, 0, 0, "R5");
    step(0, 0, 1, 0, 0, "R6");
    step(0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, "R7");
    // R8: new limit used the cycle after the write
    step(50, 0, 0, 1, 40, "R8");
    step(50, 0, 0, 0, 0, "R8");
    step(39, 39, 0, 0, 0, "R8");
    for (int li = 0; li < 4; li++) begin
      step(0, 0, 0, 1, lims[li], "R8");
      for (int t = 0; t < 272; t += 7) begin
        for (int r = 0; r < 272; r += 17) begin
          step(t, r, 0, 0, 0, "R2");
          if (mBo) begin
            step(t, r, 0, 0, 0, "R5");
            step(t, r, 1, 0, 0, "R6");
          end
        end
      end
    end
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule